// File: doc/BRIEF.md
# LVDS Bit Mapping Serializer

This block places one 24-bit RGB pixel, together with its horizontal sync, vertical sync and data-enable flags, onto the 28 bit slots of a four-lane LVDS link. Each slot has its own 5-bit source selector, so software decides the whole colour-to-wire layout. Common panel orderings are simply different selector tables, and any other ordering can be built the same way. Each lane is then sent 7:1, one bit per bit-clock strobe, next to a clock lane that repeats a fixed pattern in every pixel period.

A single-cycle write port loads seven mapping registers and one configuration register. The configuration register enables the link and chooses between single-link and dual-link operation. In dual-link mode the block takes two pixels in each link period. The first pixel goes to link 0 and the second to link 1, and both links use the same selector table. The block uses one clock. A strobe input `bit_ce`, pulsed seven times per pixel period, paces the serial output, and a `pix_take` output tells the pixel source in which cycles a pixel is sampled.

Top module: `lvds_slot_serializer`

## Requirements
- R1: After reset the link is disabled, all outputs and `pix_take` are low, and every slot selector holds code 27, so once the link is enabled every data lane stays low until a mapping is written.
- R2: A write to address 7 is the configuration register: bit 0 enables the link and bit 1 selects dual-link. All other bits are ignored. While the link is disabled every lane and clock output is low, `pix_take` stays low, and the bit counter restarts at bit time 0 when the link is enabled again.
- R3: A write to address a (0 to 6) sets the selectors of slots 4a, 4a+1, 4a+2 and 4a+3 from bits 4:0, 12:8, 20:16 and 28:24 of the data. The three bits above each selector are ignored.
- R4: Selector codes 0 to 7 pick red bits 0 to 7, codes 8 to 15 pick green bits 0 to 7, codes 16 to 23 pick blue bits 0 to 7, code 24 picks HS, code 25 picks VS and code 26 picks DE. Codes 27 to 31 give a constant low.
- R5: Slot s is sent on data lane s/7 during bit time s%7 of the link period. Bit time 0 begins with the strobe that loads a pixel, and each later strobe moves on by one bit time.
- R6: While enabled, the clock lane of an active link shows 1,1,0,0,0,1,1 in bit times 0 to 6.
- R7: In single-link mode `pix_take` is high only in a cycle that is in bit time 6 and has `bit_ce` high. The pixel present at that edge goes out on link 0 in the following period, and link 1 (data and clock) stays low.
- R8: In dual-link mode `pix_take` is also high in a strobe cycle in bit time 2. The pixel taken in bit time 2 goes out on link 0 and the pixel taken in bit time 6 goes out on link 1 in the following period. Both links use the same selectors and both clock lanes run.
- R9: A mapping write does not change the period already being sent. It applies from the next pixel load.
- R10: The outputs change only at edges where `bit_ce` is high or a write is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address: 0-6 mapping, 7 configuration |
| cfg_wdata | input | 32 | Register write data |
| bit_ce | input | 1 | Bit-time strobe, seven per pixel period |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| pix_take | output | 1 | Pixel on the inputs is sampled at this edge |
| l0_data | output | 4 | Link 0 serial data lanes |
| l0_clk | output | 1 | Link 0 clock lane |
| l1_data | output | 4 | Link 1 serial data lanes |
| l1_clk | output | 1 | Link 1 clock lane |

## Verification
A wrong bit counter shows up within one strobe: the clock lane leaves its 1,1,0,0,0,1,1 rhythm, and `pix_take` fires at the wrong bit time. A selector written to the wrong slot, or with the wrong field, corrupts one lane bit in the period after the next pixel load, so every lane word is compared bit by bit against a table built from the written selectors. A pixel held back in dual-link mode, or an early update of the mapping, only appears after the following load, which is why the test runs several periods with changing pixels.

// File: rtl/lvds_slot_serializer.sv
module lvds_slot_serializer #(
  parameter int LANES = 4,
  parameter int BITS = 7,
  parameter int AW = $clog2(LANES * BITS / 4 + 1),
  parameter logic [BITS-1:0] CLK_PAT = 7'b1100011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              bit_ce,
  input  logic [7:0]        pix_r,
  input  logic [7:0]        pix_g,
  input  logic [7:0]        pix_b,
  input  logic              pix_hs,
  input  logic              pix_vs,
  input  logic              pix_de,
  output logic              pix_take,
  output logic [LANES-1:0]  l0_data,
  output logic              l0_clk,
  output logic [LANES-1:0]  l1_data,
  output logic              l1_clk
);
  localparam int NSLOT = LANES * BITS;
  localparam int NREG = NSLOT / 4;
  localparam int PW = $clog2(BITS);
  localparam int MID_PH = BITS / 2 - 1;
  localparam logic [AW-1:0] CFG_ADDR = AW'(NREG);
  localparam logic [4:0] SEL_LOW = 5'd27;

  logic [4:0]      sel_q [NSLOT];
  logic            en_q, dual_q;
  logic [PW-1:0]   phase_q;
  logic [31:0]     hold_q;
  logic [BITS-1:0] word0_q [LANES];
  logic [BITS-1:0] word1_q [LANES];
  logic [BITS-1:0] map_now [LANES];
  logic [BITS-1:0] map_hold [LANES];

  logic [31:0] src_now;
  logic        last_bit, mid_bit;

  assign src_now  = {5'b0, pix_de, pix_vs, pix_hs, pix_b, pix_g, pix_r};
  assign last_bit = en_q & bit_ce & (phase_q == PW'(BITS - 1));
  assign mid_bit  = en_q & bit_ce & dual_q & (phase_q == PW'(MID_PH));
  assign pix_take = last_bit | mid_bit;

  wire unused_wdata = &{1'b0, cfg_wdata[31:29], cfg_wdata[23:21],
                        cfg_wdata[15:13], cfg_wdata[7:5]};

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      for (int k = 0; k < BITS; k++) begin
        map_now[l][k]  = src_now[sel_q[l*BITS+k]];
        map_hold[l][k] = hold_q[sel_q[l*BITS+k]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      dual_q  <= 1'b0;
      phase_q <= '0;
      hold_q  <= '0;
      for (int s = 0; s < NSLOT; s++) sel_q[s] <= SEL_LOW;
      for (int l = 0; l < LANES; l++) begin
        word0_q[l] <= '0;
        word1_q[l] <= '0;
      end
    end else begin
      if (cfg_we) begin
        if (cfg_addr == CFG_ADDR) begin
          en_q   <= cfg_wdata[0];
          dual_q <= cfg_wdata[1];
        end
        for (int a = 0; a < NREG; a++)
          if (cfg_addr == AW'(a))
            for (int j = 0; j < 4; j++)
              sel_q[4*a+j] <= cfg_wdata[8*j +: 5];
      end
      if (!en_q) begin
        phase_q <= '0;
        for (int l = 0; l < LANES; l++) begin
          word0_q[l] <= '0;
          word1_q[l] <= '0;
        end
      end else if (bit_ce) begin
        phase_q <= last_bit ? '0 : phase_q + 1'b1;
        if (mid_bit) hold_q <= src_now;
        if (last_bit)
          for (int l = 0; l < LANES; l++) begin
            word0_q[l] <= dual_q ? map_hold[l] : map_now[l];
            word1_q[l] <= dual_q ? map_now[l] : '0;
          end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign l0_data[l] = en_q & word0_q[l][phase_q];
    assign l1_data[l] = en_q & dual_q & word1_q[l][phase_q];
  end
  assign l0_clk = en_q & CLK_PAT[phase_q];
  assign l1_clk = en_q & dual_q & CLK_PAT[phase_q];
endmodule

// File: rtl/lvds_slot_serializer_chk.sv
module lvds_slot_serializer_chk #(
  parameter int LANES = 4,
  parameter int BITS = 7,
  parameter int AW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [AW-1:0]    cfg_addr,
  input logic [31:0]      cfg_wdata,
  input logic             bit_ce,
  input logic             pix_take,
  input logic [LANES-1:0] l0_data,
  input logic             l0_clk,
  input logic [LANES-1:0] l1_data,
  input logic             l1_clk,
  input logic             en_q,
  input logic             dual_q,
  input logic [$clog2(BITS)-1:0] phase_q
);
  localparam logic [AW-1:0] CFG_ADDR = AW'(LANES * BITS / 4);

  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CFG_ADDR && !cfg_wdata[0]) |=>
      (l0_data == '0 && !l0_clk && l1_data == '0 && !l1_clk && !pix_take));

  p_phase_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < BITS);

  p_clk_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && bit_ce && phase_q == BITS - 1 && !cfg_we) |=> l0_clk);

  p_take_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_take |-> (bit_ce && en_q));

  p_single_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_take && !dual_q) |-> phase_q == BITS - 1);

  p_link1_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_q |-> (l1_data == '0 && !l1_clk));

  p_quiet_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_ce && !cfg_we) |=>
      ($stable(l0_data) && $stable(l1_data) && $stable(l0_clk) && $stable(l1_clk)));
endmodule

bind lvds_slot_serializer lvds_slot_serializer_chk #(
  .LANES(LANES), .BITS(BITS), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .bit_ce(bit_ce), .pix_take(pix_take),
  .l0_data(l0_data), .l0_clk(l0_clk), .l1_data(l1_data), .l1_clk(l1_clk),
  .en_q(en_q), .dual_q(dual_q), .phase_q(phase_q)
);

// File: tb/tb_lvds_slot_serializer.sv
module tb_lvds_slot_serializer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic bit_ce = 1'b0;
  logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic pix_hs = 1'b0, pix_vs = 1'b0, pix_de = 1'b0;
  logic pix_take;
  logic [3:0] l0_data, l1_data;
  logic l0_clk, l1_clk;

  int checks = 0, failures = 0;
  bit done = 0;

  int m_sel [28];
  bit m_en = 0, m_dual = 0;
  int bph = 0;
  logic [31:0] m_hold = '0;
  logic [6:0] e0 [4];
  logic [6:0] e1 [4];
  logic [31:0] seed = 32'h1234_5678;
  localparam logic [6:0] PAT = 7'b1100011;

  always #10 clk = ~clk;

  lvds_slot_serializer dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bit_ce(bit_ce), .pix_r(pix_r), .pix_g(pix_g),
    .pix_b(pix_b), .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de),
    .pix_take(pix_take), .l0_data(l0_data), .l0_clk(l0_clk),
    .l1_data(l1_data), .l1_clk(l1_clk)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic check_out(input string tag);
    logic [3:0] x0, x1;
    for (int l = 0; l < 4; l++) begin
      x0[l] = m_en & e0[l][bph];
      x1[l] = m_en & m_dual & e1[l][bph];
    end
    check(tag, "link0 data", 32'(l0_data), 32'(x0));
    check(tag, "link1 data", 32'(l1_data), 32'(x1));
    check("R6", "link0 clock", 32'(l0_clk), 32'(m_en & PAT[bph]));
    check("R6", "link1 clock", 32'(l1_clk), 32'(m_en & m_dual & PAT[bph]));
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (a == 3'd7) begin
      m_en = d[0]; m_dual = d[1];
      if (!d[0]) begin
        bph = 0;
        for (int l = 0; l < 4; l++) begin e0[l] = '0; e1[l] = '0; end
      end
    end else begin
      for (int j = 0; j < 4; j++) m_sel[4*a+j] = int'(d[8*j +: 5]);
    end
  endtask

  task automatic map_write(input int a, input int c0, input int c1,
                           input int c2, input int c3);
    cfg_write(3'(a), {3'b101, 5'(c3), 3'b101, 5'(c2), 3'b101, 5'(c1), 3'b101, 5'(c0)});
  endtask

  function automatic logic [6:0] lane_word(input logic [31:0] src, input int l);
    logic [6:0] w;
    for (int k = 0; k < 7; k++) w[k] = src[m_sel[l*7+k]];
    return w;
  endfunction

  task automatic strobe(input string tag, input logic [31:0] src);
    bit exp_take;
    {pix_de, pix_vs, pix_hs, pix_b, pix_g, pix_r} = src[26:0];
    bit_ce = 1'b1;
    #1;
    exp_take = m_en && (bph == 6 || (m_dual && bph == 2));
    check(m_dual ? "R8" : "R7", "pix_take", 32'(pix_take), 32'(exp_take));
    @(posedge clk); #1;
    bit_ce = 1'b0;
    if (m_en) begin
      if (m_dual && bph == 2) m_hold = src;
      if (bph == 6)
        for (int l = 0; l < 4; l++) begin
          e0[l] = m_dual ? lane_word(m_hold, l) : lane_word(src, l);
          e1[l] = m_dual ? lane_word(src, l) : 7'd0;
        end
      bph = (bph == 6) ? 0 : bph + 1;
    end
    check_out(tag);
    @(posedge clk); #1;
    check_out("R10");
  endtask

  function automatic logic [31:0] next_pix();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return {5'b0, seed[31:5]};
  endfunction

  task automatic t_reset();
    bit_ce = 1'b1; #1;
    check("R1", "pix_take after reset", 32'(pix_take), 0);
    check("R1", "outputs after reset", 32'({l0_data, l0_clk, l1_data, l1_clk}), 0);
    @(posedge clk); #1; bit_ce = 1'b0;
    check("R1", "outputs after strobe while off", 32'({l0_data, l0_clk, l1_data, l1_clk}), 0);
  endtask

  task automatic t_defaults();
    cfg_write(3'd7, 32'h1);
    check_out("R6");
    for (int i = 0; i < 14; i++) strobe("R1", 32'h07FF_FFFF);
  endtask

  task automatic t_mapping();
    for (int a = 0; a < 7; a++) map_write(a, 4*a, 4*a+1, 4*a+2, 4*a+3);
    for (int i = 0; i < 21; i++) strobe("R5", next_pix());
    for (int i = 0; i < 14; i++) strobe("R3", 32'h0555_AAAA ^ (32'(i) << 20));
    for (int a = 0; a < 7; a++)
      map_write(a, (11*(4*a)+5)%32, (11*(4*a+1)+5)%32, (11*(4*a+2)+5)%32, (11*(4*a+3)+5)%32);
    for (int i = 0; i < 21; i++) strobe("R4", (i % 3 == 0) ? 32'h07FF_FFFF : next_pix());
  endtask

  task automatic t_midwrite();
    while (bph != 3) strobe("R5", next_pix());
    map_write(0, 26, 26, 26, 26);
    map_write(5, 31, 28, 0, 8);
    check_out("R9");
    for (int i = 0; i < 14; i++) strobe("R9", next_pix());
  endtask

  task automatic t_dual();
    cfg_write(3'd7, 32'h0);
    cfg_write(3'd7, 32'h3);
    check("R2", "link0 clock after re-enable", 32'(l0_clk), 1);
    for (int i = 0; i < 28; i++) strobe("R8", next_pix());
  endtask

  task automatic t_cfg();
    cfg_write(3'd7, 32'hFFFF_FFF1);
    for (int i = 0; i < 10; i++) strobe("R7", next_pix());
    cfg_write(3'd7, 32'hFFFF_FFF0);
    check("R2", "outputs when disabled", 32'({l0_data, l0_clk, l1_data, l1_clk}), 0);
    for (int i = 0; i < 8; i++) strobe("R2", next_pix());
    cfg_write(3'd7, 32'h1);
    for (int i = 0; i < 14; i++) strobe("R2", next_pix());
  endtask

  initial begin
    for (int s = 0; s < 28; s++) m_sel[s] = 27;
    for (int l = 0; l < 4; l++) begin e0[l] = '0; e1[l] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_defaults();
    t_mapping();
    t_midwrite();
    t_dual();
    t_cfg();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule